// File: doc/BRIEF.md
# PHY Control-Register Handshake Master

This block performs one register access at a time on the parallel control-register port of a PHY. A host presents a command made up of a direction, a PHY index, a register address and, for writes, a data word. The block then runs a four-phase handshake on the chosen PHY's port. It raises the relevant enable and waits for the acknowledge line to go high. Next it drops the enable and waits for acknowledge to return low. When both phases are over it reports completion with a one-cycle done pulse, and a read also returns the data word.

Each wait phase samples acknowledge at a fixed poll interval, counted in system clock cycles, and allows only a bounded number of samples. If the expected level is not seen in time, the access ends with a timeout flag and both enables are released. Every PHY has its own port-select line. The first access to a PHY asserts that line and then waits a settling time before any handshake is started on it.

Top module: `phyreg_hs_master`

## Requirements
- R1: While `busy` is low, a cycle with `cmd_valid` high is accepted and `busy` is high from the next cycle until the cycle in which `done` pulses. A command presented while `busy` is high is ignored and changes no output.
- R2: `cmd_phy` = n selects PHY n. If `phy_sel[n]` is low when the command is accepted, the block raises it and keeps the enables low for at least `SETTLE_CYC` further cycles. Once raised, a select bit stays high until reset. An access to a PHY that is already selected skips the settling time.
- R3: The address (and, for a write, the data word) of the accepted command appear on the PHY's field, bits [n*W +: W], at least one cycle before its enable rises. The fields of the other PHYs are not changed.
- R4: A write (`cmd_write` = 1) raises `phy_wr_en[n]` and holds it until a poll sees `phy_ack[n]` high. It then drops the enable and waits for a poll that sees `phy_ack[n]` low.
- R5: A read (`cmd_write` = 0) does the same with `phy_rd_en[n]`. `rdata` takes the PHY's read-data field at the poll that first sees acknowledge high, and it holds that value until the next successful read capture.
- R6: In each wait phase, acknowledge is sampled on the first cycle of the phase and then every `POLL_CYC` cycles, at most `MAX_POLLS` times. An expected level seen at the last allowed sample still counts as success.
- R7: If the last allowed sample of a phase misses, both enables go low, `done` and `timeout_err` pulse together for one cycle and the block returns to idle.
- R8: A successful access ends with `done` high for exactly one cycle, with `timeout_err` low, on the cycle after the poll that sees acknowledge low. `busy` falls on that same edge.
- R9: At most one enable line across all PHYs is high at any time, and only on the PHY of the command in progress. No enable is high while `busy` is low.
- R10: During reset all outputs are low: `busy`, `done`, `timeout_err`, `rdata`, every select, enable, address and data field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_phy | input | IDX_W | Target PHY index |
| cmd_addr | input | ADDR_W | Register address |
| cmd_wdata | input | DATA_W | Write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout_err | output | 1 | Pulses with done when an access timed out |
| rdata | output | DATA_W | Last captured read data |
| phy_sel | output | NUM_PHY | Per-PHY port select |
| phy_addr | output | NUM_PHY*ADDR_W | Per-PHY register address |
| phy_wdata | output | NUM_PHY*DATA_W | Per-PHY write data |
| phy_wr_en | output | NUM_PHY | Per-PHY write enable |
| phy_rd_en | output | NUM_PHY | Per-PHY read enable |
| phy_ack | input | NUM_PHY | Per-PHY acknowledge |
| phy_rdata | input | NUM_PHY*DATA_W | Per-PHY read data |

## Verification
The checker module checks several rules on every cycle. Only one enable may be high, and only while busy. No enable may be high on an unselected port. A select bit never falls, and the address is steady when an enable rises. An enable may fall only after acknowledge was high or together with a timeout, and done excludes busy. Cycle-exact timing is shown only by the bench scenarios, which compare against the reference model with a responder of adjustable delay: the settling wait, the poll spacing, success at the last allowed poll against timeout one cycle later, read capture and the dropping of a command issued while busy.

// File: rtl/phyreg_pkg.sv
package phyreg_pkg;
   typedef enum logic [2:0] {
      S_IDLE,
      S_SETTLE,
      S_PRESENT,
      S_WAIT_HI,
      S_WAIT_LO
   } hs_state_e;

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/phyreg_poll_timer.sv
module phyreg_poll_timer #(
   parameter int POLL_CYC  = 1250,
   parameter int MAX_POLLS = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic run,
   output logic poll_now,
   output logic last_poll
);
   localparam int PW = $clog2(MAX_POLLS + 1);

   logic [PW-1:0] npoll;
   logic          tick;

   generate
      if (POLL_CYC == 1) begin : g_every_cycle
         assign tick = 1'b1;
      end else begin : g_interval
         localparam int IVW = $clog2(POLL_CYC);
         logic [IVW-1:0] ivl;
         always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
               ivl <= '0;
            end else if (run) begin
               if (ivl == '0) ivl <= IVW'(POLL_CYC - 1);
               else           ivl <= ivl - 1'b1;
            end
         end
         assign tick = (ivl == '0);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         npoll <= '0;
      end else if (run && tick) begin
         npoll <= npoll + 1'b1;
      end
   end

   assign poll_now  = run && tick;
   assign last_poll = (npoll == PW'(MAX_POLLS - 1));
endmodule

// File: rtl/phyreg_port_bank.sv
module phyreg_port_bank #(
   parameter int NUM_PHY = 2,
   parameter int IDX_W   = 1,
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 32
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      load,
   input  logic [IDX_W-1:0]          load_idx,
   input  logic                      load_write,
   input  logic [ADDR_W-1:0]         load_addr,
   input  logic [DATA_W-1:0]         load_wdata,
   input  logic [IDX_W-1:0]          cur_idx,
   input  logic                      sel_set,
   input  logic                      en_set,
   input  logic                      en_clr,
   input  logic                      wr_mode,
   input  logic [NUM_PHY-1:0]        phy_ack,
   input  logic [NUM_PHY*DATA_W-1:0] phy_rdata,
   output logic [NUM_PHY-1:0]        phy_sel,
   output logic [NUM_PHY*ADDR_W-1:0] phy_addr,
   output logic [NUM_PHY*DATA_W-1:0] phy_wdata,
   output logic [NUM_PHY-1:0]        phy_wr_en,
   output logic [NUM_PHY-1:0]        phy_rd_en,
   output logic                      ack_cur,
   output logic [DATA_W-1:0]         rdata_cur
);
   generate
      for (genvar g = 0; g < NUM_PHY; g++) begin : g_port
         logic hit_load, hit_cur;
         assign hit_load = load && (load_idx == IDX_W'(g));
         assign hit_cur  = (cur_idx == IDX_W'(g));

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               phy_addr[g*ADDR_W +: ADDR_W]  <= '0;
               phy_wdata[g*DATA_W +: DATA_W] <= '0;
            end else if (hit_load) begin
               phy_addr[g*ADDR_W +: ADDR_W] <= load_addr;
               if (load_write) phy_wdata[g*DATA_W +: DATA_W] <= load_wdata;
            end
         end

         always_ff @(posedge clk) begin
            if (!rst_n)                phy_sel[g] <= 1'b0;
            else if (sel_set && hit_cur) phy_sel[g] <= 1'b1;
         end

         always_ff @(posedge clk) begin
            if (!rst_n || en_clr) begin
               phy_wr_en[g] <= 1'b0;
               phy_rd_en[g] <= 1'b0;
            end else if (en_set && hit_cur) begin
               phy_wr_en[g] <= wr_mode;
               phy_rd_en[g] <= !wr_mode;
            end
         end
      end
   endgenerate

   always_comb begin
      ack_cur   = 1'b0;
      rdata_cur = '0;
      for (int i = 0; i < NUM_PHY; i++) begin
         if (cur_idx == IDX_W'(i)) begin
            ack_cur   = phy_ack[i];
            rdata_cur = phy_rdata[i*DATA_W +: DATA_W];
         end
      end
   end
endmodule

// File: rtl/phyreg_hs_seq.sv
module phyreg_hs_seq
   import phyreg_pkg::*;
#(
   parameter int NUM_PHY    = 2,
   parameter int IDX_W      = 1,
   parameter int DATA_W     = 32,
   parameter int SETTLE_CYC = 125
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_valid,
   input  logic               cmd_write,
   input  logic [IDX_W-1:0]   cmd_phy,
   input  logic [NUM_PHY-1:0] phy_sel,
   input  logic               ack_cur,
   input  logic [DATA_W-1:0]  rdata_cur,
   input  logic               poll_now,
   input  logic               last_poll,
   output logic               busy,
   output logic               done,
   output logic               timeout_err,
   output logic [DATA_W-1:0]  rdata,
   output logic               load,
   output logic [IDX_W-1:0]   cur_idx,
   output logic               wr_mode,
   output logic               sel_set,
   output logic               en_set,
   output logic               en_clr,
   output logic               tmr_clear,
   output logic               tmr_run
);
   localparam int SW = $clog2(SETTLE_CYC + 2);

   hs_state_e     state;
   logic [SW-1:0] settle_cnt;
   logic          in_wait, matched, hit, miss_last;

   always_comb begin
      in_wait   = (state == S_WAIT_HI) || (state == S_WAIT_LO);
      matched   = (state == S_WAIT_HI) ? ack_cur : !ack_cur;
      hit       = in_wait && poll_now && matched;
      miss_last = in_wait && poll_now && !matched && last_poll;
      load      = (state == S_IDLE) && cmd_valid;
      sel_set   = (state == S_SETTLE);
      en_set    = (state == S_PRESENT);
      en_clr    = hit || miss_last;
      tmr_clear = en_set || hit;
      tmr_run   = in_wait;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state       <= S_IDLE;
         cur_idx     <= '0;
         wr_mode     <= 1'b0;
         settle_cnt  <= '0;
         done        <= 1'b0;
         timeout_err <= 1'b0;
         rdata       <= '0;
      end else begin
         done        <= 1'b0;
         timeout_err <= 1'b0;
         unique case (state)
            S_IDLE: if (cmd_valid) begin
               cur_idx    <= cmd_phy;
               wr_mode    <= cmd_write;
               settle_cnt <= SW'(SETTLE_CYC);
               state      <= phy_sel[cmd_phy] ? S_PRESENT : S_SETTLE;
            end
            S_SETTLE: begin
               if (settle_cnt == '0) state <= S_PRESENT;
               else                  settle_cnt <= settle_cnt - 1'b1;
            end
            S_PRESENT: state <= S_WAIT_HI;
            S_WAIT_HI, S_WAIT_LO: begin
               if (hit) begin
                  if (state == S_WAIT_HI) begin
                     if (!wr_mode) rdata <= rdata_cur;
                     state <= S_WAIT_LO;
                  end else begin
                     done  <= 1'b1;
                     state <= S_IDLE;
                  end
               end else if (miss_last) begin
                  done        <= 1'b1;
                  timeout_err <= 1'b1;
                  state       <= S_IDLE;
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   assign busy = (state != S_IDLE);
endmodule

// File: rtl/phyreg_hs_master.sv
module phyreg_hs_master #(
   parameter int NUM_PHY    = 2,
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 32,
   parameter int POLL_CYC   = 1250,
   parameter int MAX_POLLS  = 10,
   parameter int SETTLE_CYC = 125,
   localparam int IDX_W     = phyreg_pkg::idx_width(NUM_PHY)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cmd_valid,
   input  logic                      cmd_write,
   input  logic [IDX_W-1:0]          cmd_phy,
   input  logic [ADDR_W-1:0]         cmd_addr,
   input  logic [DATA_W-1:0]         cmd_wdata,
   output logic                      busy,
   output logic                      done,
   output logic                      timeout_err,
   output logic [DATA_W-1:0]         rdata,
   output logic [NUM_PHY-1:0]        phy_sel,
   output logic [NUM_PHY*ADDR_W-1:0] phy_addr,
   output logic [NUM_PHY*DATA_W-1:0] phy_wdata,
   output logic [NUM_PHY-1:0]        phy_wr_en,
   output logic [NUM_PHY-1:0]        phy_rd_en,
   input  logic [NUM_PHY-1:0]        phy_ack,
   input  logic [NUM_PHY*DATA_W-1:0] phy_rdata
);
   generate
      if (NUM_PHY < 1 || ADDR_W < 1 || DATA_W < 1 || POLL_CYC < 1 ||
          MAX_POLLS < 1 || SETTLE_CYC < 0) begin : g_bad_param
         $error("phyreg_hs_master: parameter out of range");
      end
   endgenerate

   logic              load, wr_mode, sel_set, en_set, en_clr;
   logic              tmr_clear, tmr_run, poll_now, last_poll;
   logic              ack_cur;
   logic [IDX_W-1:0]  cur_idx;
   logic [DATA_W-1:0] rdata_cur;

   phyreg_hs_seq #(
      .NUM_PHY(NUM_PHY), .IDX_W(IDX_W), .DATA_W(DATA_W), .SETTLE_CYC(SETTLE_CYC)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_phy(cmd_phy),
      .phy_sel(phy_sel), .ack_cur(ack_cur), .rdata_cur(rdata_cur),
      .poll_now(poll_now), .last_poll(last_poll),
      .busy(busy), .done(done), .timeout_err(timeout_err), .rdata(rdata),
      .load(load), .cur_idx(cur_idx), .wr_mode(wr_mode),
      .sel_set(sel_set), .en_set(en_set), .en_clr(en_clr),
      .tmr_clear(tmr_clear), .tmr_run(tmr_run)
   );

   phyreg_poll_timer #(
      .POLL_CYC(POLL_CYC), .MAX_POLLS(MAX_POLLS)
   ) u_timer (
      .clk(clk), .rst_n(rst_n), .clear(tmr_clear), .run(tmr_run),
      .poll_now(poll_now), .last_poll(last_poll)
   );

   phyreg_port_bank #(
      .NUM_PHY(NUM_PHY), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) u_bank (
      .clk(clk), .rst_n(rst_n),
      .load(load), .load_idx(cmd_phy), .load_write(cmd_write),
      .load_addr(cmd_addr), .load_wdata(cmd_wdata),
      .cur_idx(cur_idx), .sel_set(sel_set), .en_set(en_set), .en_clr(en_clr),
      .wr_mode(wr_mode), .phy_ack(phy_ack), .phy_rdata(phy_rdata),
      .phy_sel(phy_sel), .phy_addr(phy_addr), .phy_wdata(phy_wdata),
      .phy_wr_en(phy_wr_en), .phy_rd_en(phy_rd_en),
      .ack_cur(ack_cur), .rdata_cur(rdata_cur)
   );
endmodule

// File: rtl/phyreg_hs_master_chk.sv
module phyreg_hs_master_chk #(
   parameter int NUM_PHY = 2,
   parameter int ADDR_W  = 16
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      cmd_valid,
   input logic                      busy,
   input logic                      done,
   input logic                      timeout_err,
   input logic [NUM_PHY-1:0]        phy_sel,
   input logic [NUM_PHY*ADDR_W-1:0] phy_addr,
   input logic [NUM_PHY-1:0]        phy_wr_en,
   input logic [NUM_PHY-1:0]        phy_rd_en,
   input logic [NUM_PHY-1:0]        phy_ack
);
   logic [NUM_PHY-1:0] any_en;
   assign any_en = phy_wr_en | phy_rd_en;

   p_accept_needs_cmd_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(cmd_valid));

   p_en_only_selected_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (any_en & ~phy_sel) == '0);

   p_sel_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(phy_sel) & ~phy_sel) == '0);

   p_addr_before_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(|any_en) |-> $stable(phy_addr));

   p_drop_on_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(|any_en) |-> ($past(|phy_ack) || timeout_err));

   p_timeout_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_err |-> (done && any_en == '0));

   p_done_ends_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   p_single_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({phy_wr_en, phy_rd_en}));

   p_idle_no_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (any_en == '0));
endmodule

bind phyreg_hs_master phyreg_hs_master_chk #(
   .NUM_PHY(NUM_PHY), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/phyreg_hs_master_bench.sv
module phyreg_hs_master_bench;
   localparam int NP = 2;
   localparam int AW = 16;
   localparam int DW = 32;
   localparam int PC = 3;
   localparam int MP = 10;
   localparam int SC = 4;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic           rst_n = 1'b0;
   logic           cmd_valid = 1'b0, cmd_write = 1'b0;
   logic [0:0]     cmd_phy = '0;
   logic [AW-1:0]  cmd_addr = '0;
   logic [DW-1:0]  cmd_wdata = '0;
   logic           busy, done, timeout_err;
   logic [DW-1:0]  rdata;
   logic [NP-1:0]  phy_sel, phy_wr_en, phy_rd_en;
   logic [NP*AW-1:0] phy_addr;
   logic [NP*DW-1:0] phy_wdata, phy_rdata;
   logic [NP-1:0]  ack_r;

   phyreg_hs_master #(
      .NUM_PHY(NP), .ADDR_W(AW), .DATA_W(DW),
      .POLL_CYC(PC), .MAX_POLLS(MP), .SETTLE_CYC(SC)
   ) u_phyreg_hs_master (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
      .cmd_phy(cmd_phy), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
      .busy(busy), .done(done), .timeout_err(timeout_err), .rdata(rdata),
      .phy_sel(phy_sel), .phy_addr(phy_addr), .phy_wdata(phy_wdata),
      .phy_wr_en(phy_wr_en), .phy_rd_en(phy_rd_en),
      .phy_ack(ack_r), .phy_rdata(phy_rdata)
   );

   function automatic logic [DW-1:0] init_word(input int p, input int i);
      return 32'h0100_0000 * (p + 1) + 32'(i * 7 + 1);
   endfunction

   // ---------------- PHY responder ----------------
   int           rise_d [NP];
   int           fall_d [NP];
   bit           no_rise[NP];
   bit           no_fall[NP];
   int           rcnt   [NP];
   logic         en_prev[NP];
   logic [DW-1:0] mem   [NP][16];

   initial begin
      for (int p = 0; p < NP; p++)
         for (int i = 0; i < 16; i++) mem[p][i] = init_word(p, i);
   end

   always @(posedge clk) begin
      for (int p = 0; p < NP; p++) begin
         logic en;
         en = phy_wr_en[p] | phy_rd_en[p];
         if (!rst_n) begin
            rcnt[p] = 0; en_prev[p] = 1'b0; ack_r[p] <= 1'b0;
         end else begin
            if (en != en_prev[p]) rcnt[p] = 0; else rcnt[p] = rcnt[p] + 1;
            en_prev[p] = en;
            if (en && !no_rise[p] && rcnt[p] >= rise_d[p] && !ack_r[p]) begin
               ack_r[p] <= 1'b1;
               if (phy_wr_en[p]) mem[p][phy_addr[p*AW +: 4]] <= phy_wdata[p*DW +: DW];
            end
            if (!en && !no_fall[p] && rcnt[p] >= fall_d[p]) ack_r[p] <= 1'b0;
         end
      end
   end

   for (genvar g = 0; g < NP; g++) begin : g_rd
      assign phy_rdata[g*DW +: DW] = mem[g][phy_addr[g*AW +: 4]];
   end

   // ---------------- reference model ----------------
   int            ms, mi, mcnt, mel;   // ms: 0 idle,1 settle,2 present,3 wait hi,4 wait lo
   bit            mw, mdone, mto;
   logic [NP-1:0] msel, mwr, mrd;
   logic [AW-1:0] maddr[NP];
   logic [DW-1:0] mwd  [NP];
   logic [DW-1:0] mrdata;
   logic [DW-1:0] mmem [NP][16];

   initial begin
      for (int p = 0; p < NP; p++)
         for (int i = 0; i < 16; i++) mmem[p][i] = init_word(p, i);
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         ms = 0; mi = 0; mcnt = 0; mel = 0; mw = 0; mdone = 0; mto = 0;
         msel = '0; mwr = '0; mrd = '0; mrdata = '0;
         for (int p = 0; p < NP; p++) begin maddr[p] = '0; mwd[p] = '0; end
      end else begin
         mdone = 0; mto = 0;
         case (ms)
            0: if (cmd_valid) begin
               mi = int'(cmd_phy); mw = cmd_write;
               maddr[mi] = cmd_addr;
               if (cmd_write) mwd[mi] = cmd_wdata;
               if (msel[mi]) ms = 2; else begin ms = 1; mcnt = 0; end
            end
            1: begin
               if (mcnt == 0) msel[mi] = 1'b1;
               if (mcnt == SC) ms = 2; else mcnt = mcnt + 1;
            end
            2: begin
               if (mw) mwr[mi] = 1'b1; else mrd[mi] = 1'b1;
               ms = 3; mel = 0;
            end
            default: begin
               bit want, poll;
               want = (ms == 3);
               poll = (mel % PC) == 0;
               if (poll && ack_r[mi] == want) begin
                  mwr = '0; mrd = '0;
                  if (ms == 3) begin
                     if (mw) mmem[mi][maddr[mi][3:0]] = mwd[mi];
                     else    mrdata = mmem[mi][maddr[mi][3:0]];
                     ms = 4; mel = 0;
                  end else begin
                     mdone = 1; ms = 0;
                  end
               end else if (poll && (mel / PC) == MP - 1) begin
                  mwr = '0; mrd = '0; mdone = 1; mto = 1; ms = 0;
               end else begin
                  mel = mel + 1;
               end
            end
         endcase
      end
   end

   // ---------------- checking ----------------
   int ncmp = 0, nbad = 0;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      ncmp++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         logic [NP*AW-1:0] ea;
         logic [NP*DW-1:0] ed;
         for (int p = 0; p < NP; p++) begin
            ea[p*AW +: AW] = maddr[p];
            ed[p*DW +: DW] = mwd[p];
         end
         chk("R1 busy", 64'(busy), 64'(ms != 0));
         chk("R8 done", 64'(done), 64'(mdone));
         chk("R7 timeout_err", 64'(timeout_err), 64'(mto));
         chk("R5 rdata", 64'(rdata), 64'(mrdata));
         chk("R4 wr_en", 64'(phy_wr_en), 64'(mwr));
         chk("R5 rd_en", 64'(phy_rd_en), 64'(mrd));
         chk("R2 sel", 64'(phy_sel), 64'(msel));
         chk("R3 addr", 64'(phy_addr), 64'(ea));
         chk("R3 wdata", 64'(phy_wdata), 64'(ed));
         chk("R9 single enable", 64'($countones({phy_wr_en, phy_rd_en}) <= 1), 64'd1);
      end
   end

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      ncmp++; nbad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
   end

   task automatic op(input bit w, input int p, input logic [AW-1:0] a,
                     input logic [DW-1:0] d, output bit got_to, output int bcyc);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_write = w; cmd_phy = 1'(p); cmd_addr = a; cmd_wdata = d;
      @(negedge clk);
      cmd_valid = 1'b0;
      bcyc = 0; got_to = 1'b0;
      for (int k = 0; k < 2000; k++) begin
         if (done) begin got_to = timeout_err; break; end
         if (busy) bcyc++;
         @(negedge clk);
      end
   endtask

   initial begin
      bit to; int bc;
      for (int p = 0; p < NP; p++) begin
         rise_d[p] = 1; fall_d[p] = 2; no_rise[p] = 0; no_fall[p] = 0;
      end
      repeat (4) @(negedge clk);
      // R10: reset state
      chk("R10 busy/done/to", {61'd0, busy, done, timeout_err}, 64'd0);
      chk("R10 rdata", 64'(rdata), 64'd0);
      chk("R10 sel/en", {58'd0, phy_sel, phy_wr_en, phy_rd_en}, 64'd0);
      chk("R10 addr", 64'(phy_addr), 64'd0);
      chk("R10 wdata", 64'(phy_wdata), 64'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // write to unselected PHY0 (settle path)
      op(1'b1, 0, 16'h0005, 32'hCAFE_0005, to, bc);
      chk("R4 write completes", 64'(to), 64'd0);
      chk("R2 sel phy0 raised", 64'(phy_sel), 64'b01);
      // read back
      op(1'b0, 0, 16'h0005, 32'h0, to, bc);
      chk("R5 read back", 64'(rdata), 64'hCAFE_0005);
      op(1'b0, 0, 16'h0007, 32'h0, to, bc);
      chk("R5 read init", 64'(rdata), 64'(init_word(0, 7)));

      // PHY1 with longer delays
      rise_d[1] = 5; fall_d[1] = 4;
      op(1'b1, 1, 16'h0003, 32'h1234_5678, to, bc);
      chk("R2 sel both", 64'(phy_sel), 64'b11);
      chk("R8 write phy1 no timeout", 64'(to), 64'd0);

      // command while busy is ignored
      @(negedge clk);
      cmd_valid = 1'b1; cmd_write = 1'b0; cmd_phy = 1'b1; cmd_addr = 16'h0003;
      @(negedge clk);
      cmd_write = 1'b1; cmd_phy = 1'b0; cmd_addr = 16'h00EE; cmd_wdata = 32'hDEAD_BEEF;
      repeat (3) @(negedge clk);
      cmd_valid = 1'b0;
      for (int k = 0; k < 500 && !done; k++) @(negedge clk);
      chk("R1 ignored cmd addr phy0", 64'(phy_addr[AW-1:0]), 64'h0007);
      chk("R1 ignored cmd wdata phy0", 64'(phy_wdata[DW-1:0]), 64'hCAFE_0005);
      chk("R5 read phy1", 64'(rdata), 64'h1234_5678);
      repeat (3) @(negedge clk);

      // acknowledge never rises: timeout in first phase
      no_rise[0] = 1;
      op(1'b1, 0, 16'h0002, 32'h5555_AAAA, to, bc);
      chk("R7 timeout flagged", 64'(to), 64'd1);
      chk("R6 busy span on timeout", 64'(bc), 64'(2 + (MP - 1) * PC));
      no_rise[0] = 0;

      // acknowledge never falls: timeout in second phase, data still captured
      no_fall[1] = 1;
      op(1'b0, 1, 16'h0003, 32'h0, to, bc);
      chk("R7 timeout in low phase", 64'(to), 64'd1);
      chk("R5 captured before timeout", 64'(rdata), 64'h1234_5678);
      no_fall[1] = 0;
      repeat (10) @(negedge clk);

      // boundary: acknowledge at last allowed poll vs one cycle later
      rise_d[0] = (MP - 1) * PC - 1;
      op(1'b0, 0, 16'h0005, 32'h0, to, bc);
      chk("R6 ack at last poll succeeds", 64'(to), 64'd0);
      rise_d[0] = (MP - 1) * PC;
      op(1'b0, 0, 16'h0007, 32'h0, to, bc);
      chk("R6 ack after last poll times out", 64'(to), 64'd1);
      rise_d[0] = 0;
      repeat (10) @(negedge clk);
      op(1'b0, 0, 16'h0002, 32'h0, to, bc);
      chk("R5 fast read", 64'(rdata), 64'(init_word(0, 2)));

      repeat (5) @(negedge clk);
      summary();
      $finish;
   end
endmodule